// File: doc/BRIEF.md
# Trap Entry and Privilege Controller

This block decides, at each instruction boundary, whether the instruction about to run is replaced by a trap. Three sources can request a trap:

- a synchronous request raised by the surrounding core, such as an error condition or an explicit trap instruction, with its own 8-bit trap type;
- a privilege violation, detected inside the block;
- an interrupt level, already prioritised by an external controller.

When a trap is taken, the block computes the handler address from a programmable table base and the trap type. It pulses a redirect strobe for the fetch logic and squashes the faulting instruction, so no state from that instruction is committed.

The block also holds the processor's privilege state: the current mode (user or supervisor), the mode saved at trap entry, and the trap-enable bit. A return-from-trap operation restores the saved mode and re-enables traps.

Nothing streams through this block, so it has no valid/ready handshakes. All pins are plain control and status signals. The redirect strobe cannot be stalled: the fetch logic must accept it in the cycle it appears.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, the block is in supervisor mode with traps disabled, the table base is zero, and both redirect and squash are low.
- R2: A trap taken on a boundary cycle raises redirect and squash for exactly the following cycle. In that cycle the vector equals {base[31:12], type[7:0], 4'b0000}.
- R3: The table base is loaded from the write port only in supervisor mode. A write in user mode leaves the base unchanged.
- R4: A synchronous request is taken at a boundary whether or not traps are enabled, using the supplied type.
- R5: A privileged instruction, or a return-from-trap, issued in user mode raises type 0x03. The same instruction issued in supervisor mode raises no trap.
- R6: On trap entry, the current mode is copied into the saved mode, supervisor mode is set, and traps are disabled. Supervisor mode is entered in no other way.
- R7: A return-from-trap in supervisor mode with traps disabled restores the saved mode and enables traps, without a redirect. The saved mode is user after reset.
- R8: A return-from-trap issued while traps are enabled raises type 0x02.
- R9: A nonzero interrupt level is taken only when traps are enabled and the level is above the processor interrupt level. It is taken as type 0x10 plus the level. Level 0 means no request.
- R10: Level 15 is taken even when the processor interrupt level is 15, but still requires traps to be enabled.
- R11: When several sources are active, the priority from highest to lowest is: synchronous request, privilege violation, illegal return-from-trap, interrupt.
- R12: When the boundary strobe is low, no trap is taken and the mode state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary: the next instruction is about to execute |
| sync_req_i | input | 1 | Synchronous trap request for the pending instruction |
| sync_tt_i | input | 8 | Trap type of the synchronous request |
| priv_insn_i | input | 1 | Pending instruction is privileged |
| rett_i | input | 1 | Pending instruction is a return-from-trap |
| irq_level_i | input | 4 | Prioritised interrupt level, 0 = none |
| pil_i | input | 4 | Processor interrupt level (mask threshold) |
| base_we_i | input | 1 | Table base write enable |
| base_wdata_i | input | 32 | Table base write data (bits 31:12 kept) |
| redirect_o | output | 1 | One-cycle strobe: fetch from vector_o |
| vector_o | output | 32 | Handler address |
| squash_o | output | 1 | Discard the pending instruction |
| supervisor_o | output | 1 | Current mode, 1 = supervisor |
| traps_en_o | output | 1 | Trap enable |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 8-bit trap types, 16-byte table entries and 4-bit interrupt levels. This puts the extreme level 15 and the 0x10-based interrupt type range within reach, as well as the full 20-bit base field. It walks the mode state through reset, return to user, privilege faults, illegal returns and masked and unmasked interrupts. Simultaneous requests are used to confirm the priority order, and the vector value confirms that a user-mode base write was ignored.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int TT_BITS = 8;

  typedef enum logic [2:0] {
    CAUSE_NONE,
    CAUSE_SYNC,
    CAUSE_PRIV,
    CAUSE_RETT,
    CAUSE_IRQ
  } trap_cause_e;

  localparam logic [TT_BITS-1:0] TT_ILLEGAL_RETT = 8'h02;
  localparam logic [TT_BITS-1:0] TT_PRIV_FAULT   = 8'h03;
  localparam logic [TT_BITS-1:0] TT_IRQ_BASE     = 8'h10;
endpackage

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int TT_W  = TT_BITS,
  parameter int LVL_W = 4
) (
  input  logic             boundary,
  input  logic             sync_req,
  input  logic [TT_W-1:0]  sync_tt,
  input  logic             priv_insn,
  input  logic             rett,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [LVL_W-1:0] pil,
  input  logic             super_mode,
  input  logic             traps_en,
  output trap_cause_e      cause,
  output logic [TT_W-1:0]  tt,
  output logic             take,
  output logic             rett_ok
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic priv_fault;
  logic irq_ok;

  // A return-from-trap is itself privileged.
  assign priv_fault = (priv_insn || rett) && !super_mode;
  assign irq_ok = traps_en && (irq_lvl != '0) &&
                  ((irq_lvl == LVL_MAX) || (irq_lvl > pil));

  always_comb begin
    cause = CAUSE_NONE;
    tt    = '0;
    if (boundary) begin
      if (sync_req) begin
        cause = CAUSE_SYNC;
        tt    = sync_tt;
      end else if (priv_fault) begin
        cause = CAUSE_PRIV;
        tt    = TT_W'(TT_PRIV_FAULT);
      end else if (rett && traps_en) begin
        cause = CAUSE_RETT;
        tt    = TT_W'(TT_ILLEGAL_RETT);
      end else if (irq_ok) begin
        cause = CAUSE_IRQ;
        tt    = TT_W'(TT_IRQ_BASE) + TT_W'(irq_lvl);
      end
    end
  end

  assign take    = (cause != CAUSE_NONE);
  assign rett_ok = boundary && rett && !take && super_mode && !traps_en;
endmodule

// File: rtl/trap_base_reg.sv
module trap_base_reg #(
  parameter int ADDR_W     = 32,
  parameter int TT_W       = 8,
  parameter int OFFSET_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              super_mode,
  input  logic              load,
  input  logic [TT_W-1:0]   tt,
  output logic [ADDR_W-1:0] vector_q
);
  localparam int BASE_W  = ADDR_W - TT_W - OFFSET_LSB;
  localparam int BASE_LO = TT_W + OFFSET_LSB;

  logic [BASE_W-1:0] base_q;
  logic [ADDR_W-1:0] vector_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (we && super_mode) begin
      base_q <= wdata[ADDR_W-1:BASE_LO];
    end
  end

  generate
    if (OFFSET_LSB > 0) begin : g_offset
      assign vector_d = {base_q, tt, {OFFSET_LSB{1'b0}}};
    end else begin : g_no_offset
      assign vector_d = {base_q, tt};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vector_q <= '0;
    end else if (load) begin
      vector_q <= vector_d;
    end
  end

  // R3
  base_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_q) |-> $past(we && super_mode));
endmodule

// File: rtl/priv_state.sv
module priv_state #(
  parameter bit RESET_PREV_SUPER = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic rett_ok,
  output logic super_q,
  output logic traps_en_q,
  output logic prev_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      super_q    <= 1'b1;
      traps_en_q <= 1'b0;
      prev_q     <= RESET_PREV_SUPER;
    end else if (take) begin
      prev_q     <= super_q;
      super_q    <= 1'b1;
      traps_en_q <= 1'b0;
    end else if (rett_ok) begin
      super_q    <= prev_q;
      traps_en_q <= 1'b1;
    end
  end

  // R6
  trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (super_q && !traps_en_q && (prev_q == $past(super_q))));

  // R6
  super_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(super_q) |-> $past(take));

  // R7
  rett_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rett_ok |=> (traps_en_q && (super_q == $past(prev_q))));
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TT_W       = TT_BITS,
  parameter int OFFSET_LSB = 4,
  parameter int LVL_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              sync_req_i,
  input  logic [TT_W-1:0]   sync_tt_i,
  input  logic              priv_insn_i,
  input  logic              rett_i,
  input  logic [LVL_W-1:0]  irq_level_i,
  input  logic [LVL_W-1:0]  pil_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_wdata_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              squash_o,
  output logic              supervisor_o,
  output logic              traps_en_o
);
  trap_cause_e      sel_cause;
  logic [TT_W-1:0]  sel_tt;
  logic             take;
  logic             rett_ok;
  logic             prev_super;

  trap_select #(.TT_W(TT_W), .LVL_W(LVL_W)) u_select (
    .boundary   (boundary_i),
    .sync_req   (sync_req_i),
    .sync_tt    (sync_tt_i),
    .priv_insn  (priv_insn_i),
    .rett       (rett_i),
    .irq_lvl    (irq_level_i),
    .pil        (pil_i),
    .super_mode (supervisor_o),
    .traps_en   (traps_en_o),
    .cause      (sel_cause),
    .tt         (sel_tt),
    .take       (take),
    .rett_ok    (rett_ok)
  );

  trap_base_reg #(.ADDR_W(ADDR_W), .TT_W(TT_W), .OFFSET_LSB(OFFSET_LSB)) u_base (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (base_we_i),
    .wdata      (base_wdata_i),
    .super_mode (supervisor_o),
    .load       (take),
    .tt         (sel_tt),
    .vector_q   (vector_o)
  );

  priv_state #(.RESET_PREV_SUPER(1'b0)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .rett_ok    (rett_ok),
    .super_q    (supervisor_o),
    .traps_en_q (traps_en_o),
    .prev_q     (prev_super)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o <= 1'b0;
      squash_o   <= 1'b0;
    end else begin
      redirect_o <= take;
      squash_o   <= take;
    end
  end

  // R2
  redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> $past(boundary_i));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cause == CAUSE_IRQ) |-> (traps_en_o && irq_level_i != '0));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> (!redirect_o && $stable(supervisor_o) && $stable(traps_en_o)));
endmodule

// File: tb/trap_entry_ctrl_tb.sv
module trap_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary_i, sync_req_i, priv_insn_i, rett_i, base_we_i;
  logic [7:0]  sync_tt_i;
  logic [3:0]  irq_level_i, pil_i;
  logic [31:0] base_wdata_i;
  logic        redirect_o, squash_o, supervisor_o, traps_en_o;
  logic [31:0] vector_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  trap_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .sync_req_i(sync_req_i),
    .sync_tt_i(sync_tt_i), .priv_insn_i(priv_insn_i), .rett_i(rett_i),
    .irq_level_i(irq_level_i), .pil_i(pil_i), .base_we_i(base_we_i),
    .base_wdata_i(base_wdata_i), .redirect_o(redirect_o), .vector_o(vector_o),
    .squash_o(squash_o), .supervisor_o(supervisor_o), .traps_en_o(traps_en_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    boundary_i = 0; sync_req_i = 0; sync_tt_i = 0; priv_insn_i = 0; rett_i = 0;
    irq_level_i = 0; base_we_i = 0; base_wdata_i = 0;
  endtask

  // inputs are set at a falling edge; one rising edge later, outputs are sampled
  task automatic one_cycle();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic expect_trap(input string tag, input logic [31:0] vec);
    chk(redirect_o == 1, tag, 32'(redirect_o), 1);
    chk(squash_o == 1, tag, 32'(squash_o), 1);
    chk(vector_o == vec, tag, vector_o, vec);
    chk(supervisor_o == 1 && traps_en_o == 0, tag,
        {30'd0, supervisor_o, traps_en_o}, 32'h2);
  endtask

  task automatic expect_none(input string tag);
    chk(redirect_o == 0 && squash_o == 0, tag, {30'd0, redirect_o, squash_o}, 0);
  endtask

  task automatic do_rett();
    boundary_i = 1; rett_i = 1; one_cycle();
  endtask

  task automatic t_reset();
    chk(supervisor_o == 1, "R1 mode", 32'(supervisor_o), 1);
    chk(traps_en_o == 0, "R1 enable", 32'(traps_en_o), 0);
    expect_none("R1 strobes");
  endtask

  task automatic t_base_and_rett();
    base_we_i = 1; base_wdata_i = 32'hABCDE123; one_cycle();
    do_rett();  // R7: back to saved user mode
    expect_none("R7 no redirect");
    chk(supervisor_o == 0 && traps_en_o == 1, "R7 restore",
        {30'd0, supervisor_o, traps_en_o}, 32'h1);
    base_we_i = 1; base_wdata_i = 32'h12345000; one_cycle();  // R3 user write
  endtask

  task automatic t_priv_user();
    // R5 and R11: privilege fault beats an interrupt at level 15
    boundary_i = 1; priv_insn_i = 1; irq_level_i = 15; pil_i = 0; one_cycle();
    expect_trap("R5 priv fault / R3 base kept / R11", 32'hABCDE030);
    chk(u_dut.supervisor_o == 1, "R6 supervisor set", 32'(supervisor_o), 1);
    one_cycle();
    chk(redirect_o == 0, "R2 single pulse", 32'(redirect_o), 0);
    boundary_i = 1; priv_insn_i = 1; one_cycle();
    expect_none("R5 priv in supervisor");
  endtask

  task automatic t_sync_disabled();
    boundary_i = 1; sync_req_i = 1; sync_tt_i = 8'h81; one_cycle();
    expect_trap("R4 sync with traps off", 32'hABCDE810);
    do_rett();  // saved mode is now supervisor
    chk(supervisor_o == 1 && traps_en_o == 1, "R6 saved mode supervisor",
        {30'd0, supervisor_o, traps_en_o}, 32'h3);
  endtask

  task automatic t_rett_illegal();
    boundary_i = 1; rett_i = 1; irq_level_i = 9; pil_i = 0; one_cycle();
    expect_trap("R8 illegal rett / R11 over irq", 32'hABCDE020);
    do_rett();
  endtask

  task automatic t_irq();
    boundary_i = 1; irq_level_i = 5; pil_i = 5; one_cycle();
    expect_none("R9 level equal to pil");
    boundary_i = 1; irq_level_i = 0; pil_i = 0; one_cycle();
    expect_none("R9 level zero");
    boundary_i = 1; irq_level_i = 6; pil_i = 5; one_cycle();
    expect_trap("R9 irq taken", 32'hABCDE160);
    do_rett();
    boundary_i = 1; irq_level_i = 14; pil_i = 15; one_cycle();
    expect_none("R10 level 14 masked");
    boundary_i = 1; irq_level_i = 15; pil_i = 15; one_cycle();
    expect_trap("R10 level 15", 32'hABCDE1F0);
    boundary_i = 1; irq_level_i = 15; pil_i = 0; one_cycle();
    expect_none("R10 level 15 with traps off");
  endtask

  task automatic t_priority_and_idle();
    do_rett();
    boundary_i = 1; sync_req_i = 1; sync_tt_i = 8'h40; irq_level_i = 9; pil_i = 0;
    rett_i = 1; one_cycle();
    expect_trap("R11 sync first", 32'hABCDE400);
    sync_req_i = 1; sync_tt_i = 8'h55; rett_i = 1; one_cycle();  // no boundary
    expect_none("R12 no boundary");
    chk(supervisor_o == 1 && traps_en_o == 0, "R12 state held",
        {30'd0, supervisor_o, traps_en_o}, 32'h2);
    chk(vector_o == 32'hABCDE400, "R12 vector held", vector_o, 32'hABCDE400);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle_inputs(); pil_i = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_base_and_rett();
    t_priv_user();
    t_sync_disabled();
    t_rett_illegal();
    t_irq();
    t_priority_and_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule